// File: doc/BRIEF.md
# Column-Projecting Refill Remap Engine

This block sits between a processor's cache-refill port and a word-wide memory read port. Software first describes a row-major table to it: where the table starts, how many bytes one row spans, how many rows exist, and which of up to eight 4-byte column fields are wanted. A refill of a 64-byte line whose address falls inside a fixed alias window is then served as a packed view of the table. The line holds only the selected fields, in ascending column order within a row and ascending row order across rows, with no unselected bytes between them.

The engine works out which row and column each of the sixteen packed words of the line stands for. It issues one memory read per word that exists, and returns the words upward one at a time. Words that fall past the last row come back as zero and cost no memory read. A refill whose address lies outside the alias window is a plain line fetch: sixteen consecutive word reads, returned unchanged. Only one refill is handled at a time, and configuration writes are honoured only while no refill is in progress.

Top module: `colproj_remap`

## Requirements
- R1: Configuration writes select a register with `cfg_idx`: 0 is the table base byte address, 1 is the row pitch in bytes, 2 is the row count, and 3 is the column mask in `cfg_wdata[7:0]`, where bit c selects column c. All four reset to zero. With the mask at zero, a window refill returns sixteen zero words and issues no read.
- R2: A request is remapped when its line address (`req_addr` with bits 5:0 cleared) lies in [WIN_BASE, WIN_BASE+WIN_BYTES). Any other request issues sixteen reads at line+4j, for j = 0..15, and returns the read data unchanged in that order. Bits 5:0 of `req_addr` never affect the result.
- R3: For a window line at byte offset L, word j has packed index k = L/4 + j. With S the number of set mask bits, its row is k/S and its column is the (k mod S)-th set mask bit counted from bit 0. Its read address is base + row*pitch + 4*column, and the word returned is the data of that read.
- R4: A remapped word whose row is at or beyond the row count, or any remapped word when S is 0, is returned as zero and causes no memory read.
- R5: Each refill issues exactly one memory read for every word that is not zero-filled, in word order, and no other reads.
- R6: `req_ready` is low from the cycle after a request is accepted until the sixteenth word has been handshaken. `rsp_last` is high only with the sixteenth word. `rsp_valid` and `rsp_data` hold while `rsp_ready` is low.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and `mem_req_addr` does not change.
- R8: A configuration write made while a refill is in progress is ignored. It changes neither the current line nor any later line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Refill request valid |
| req_ready | output | 1 | Engine idle, request can be accepted |
| req_addr | input | 32 | Refill byte address |
| rsp_valid | output | 1 | Returned word valid |
| rsp_ready | input | 1 | Requester accepts the returned word |
| rsp_data | output | 32 | Returned word |
| rsp_last | output | 1 | Marks the sixteenth word of the line |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Memory read data valid, in request order |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
A wrong row or slot counter in the address walker sends the next read to the wrong field. That shows up as a mismatched data word, and the bench reports it for the single line where it happens, because every word is compared with an arithmetic model. A slip in the row bound check either turns a real word into zero or issues an extra read. The per-line read count catches that at the end of the same refill. A sequencer that leaves its busy state early, or raises the last flag on the wrong word, is caught within the line, since ready and last are sampled on every cycle of every refill during sweeps over all 256 column masks.

// File: rtl/colproj_pkg.sv
package colproj_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned COLS       = 8;
  localparam int unsigned LINE_WORDS = 16;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned CNT_W      = $clog2(COLS + 1);
  localparam int unsigned COL_W      = $clog2(COLS);
  localparam int unsigned WRD_W      = $clog2(LINE_WORDS);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_SEND
  } seq_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] pitch;
    logic [ADDR_W-1:0] rows;
    logic [COLS-1:0]   mask;
  } geom_t;

  // number of selected columns
  function automatic logic [CNT_W-1:0] sel_count(input logic [COLS-1:0] m);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int c = 0; c < int'(COLS); c++) begin
      n = n + CNT_W'(m[c]);
    end
    return n;
  endfunction

  // column index of the n-th set bit, counting from bit 0
  function automatic logic [COL_W-1:0] nth_col(input logic [COLS-1:0] m,
                                               input logic [CNT_W-1:0] n);
    logic [COL_W-1:0] r;
    logic [CNT_W-1:0] seen;
    r    = '0;
    seen = '0;
    for (int c = 0; c < int'(COLS); c++) begin
      if (m[c]) begin
        if (seen == n) r = COL_W'(c);
        seen = seen + 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/colproj_cfg.sv
module colproj_cfg
  import colproj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              idle,
  output geom_t             geom
);
  logic wr_take;
  assign wr_take = wr_en && idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      geom <= '0;
    end else if (wr_take) begin
      unique case (wr_idx)
        2'd0: geom.base  <= wr_data;
        2'd1: geom.pitch <= wr_data;
        2'd2: geom.rows  <= wr_data;
        default: geom.mask <= wr_data[COLS-1:0];
      endcase
    end
  end
endmodule

// File: rtl/colproj_walk.sv
module colproj_walk
  import colproj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              advance,
  input  logic              remap_in,
  input  logic [ADDR_W-1:0] line_off,
  input  logic [ADDR_W-1:0] line_addr,
  input  geom_t             geom_in,
  output logic [ADDR_W-1:0] word_addr,
  output logic              word_zero
);
  logic              remap_q;
  geom_t             g_q;
  logic [CNT_W-1:0]  sel_q;
  logic [CNT_W-1:0]  slot_q;
  logic [ADDR_W-1:0] row_q;
  logic [ADDR_W-1:0] row_addr_q;
  logic [ADDR_W-1:0] pt_addr_q;

  logic [CNT_W-1:0]  sel_in;
  logic [CNT_W-1:0]  div_in;
  logic [ADDR_W-1:0] k0;
  logic [ADDR_W-1:0] row0;
  logic [CNT_W-1:0]  slot0;
  logic [ADDR_W-1:0] row_addr0;
  logic              slot_wrap;

  always_comb begin
    sel_in    = sel_count(geom_in.mask);
    div_in    = (sel_in == '0) ? CNT_W'(1) : sel_in;
    k0        = line_off >> 2;
    row0      = k0 / ADDR_W'(div_in);
    slot0     = CNT_W'(k0 % ADDR_W'(div_in));
    row_addr0 = geom_in.base + row0 * geom_in.pitch;
  end

  assign slot_wrap = (slot_q + 1'b1) == sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remap_q    <= 1'b0;
      g_q        <= '0;
      sel_q      <= '0;
      slot_q     <= '0;
      row_q      <= '0;
      row_addr_q <= '0;
      pt_addr_q  <= '0;
    end else if (start) begin
      remap_q    <= remap_in;
      g_q        <= geom_in;
      sel_q      <= sel_in;
      slot_q     <= slot0;
      row_q      <= row0;
      row_addr_q <= row_addr0;
      pt_addr_q  <= line_addr;
    end else if (advance) begin
      pt_addr_q <= pt_addr_q + ADDR_W'(WORD_BYTES);
      if (slot_wrap) begin
        slot_q     <= '0;
        row_q      <= row_q + 1'b1;
        row_addr_q <= row_addr_q + g_q.pitch;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign word_zero = remap_q && ((sel_q == '0) || (row_q >= g_q.rows));
  assign word_addr = remap_q
                   ? row_addr_q + (ADDR_W'(nth_col(g_q.mask, slot_q)) << 2)
                   : pt_addr_q;
endmodule

// File: rtl/colproj_seq.sv
module colproj_seq
  import colproj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              word_zero,
  output logic              start,
  output logic              advance,
  output logic              idle
);
  seq_state_t        state;
  logic [WRD_W-1:0]  wcnt;
  logic [DATA_W-1:0] data_q;
  logic              at_last;
  logic              word_done;

  assign idle          = state == ST_IDLE;
  assign req_ready     = idle;
  assign start         = req_valid && idle;
  assign at_last       = wcnt == WRD_W'(LINE_WORDS - 1);
  assign rsp_valid     = state == ST_SEND;
  assign rsp_last      = rsp_valid && at_last;
  assign rsp_data      = data_q;
  assign mem_req_valid = (state == ST_ISSUE) && !word_zero;
  assign word_done     = rsp_valid && rsp_ready;
  assign advance       = word_done && !at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      wcnt   <= '0;
      data_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          wcnt <= '0;
          if (req_valid) state <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (word_zero) begin
            data_q <= '0;
            state  <= ST_SEND;
          end else if (mem_req_ready) begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            data_q <= mem_rsp_data;
            state  <= ST_SEND;
          end
        end
        default: begin
          if (rsp_ready) begin
            if (at_last) begin
              state <= ST_IDLE;
              wcnt  <= '0;
            end else begin
              wcnt  <= wcnt + 1'b1;
              state <= ST_ISSUE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/colproj_remap.sv
module colproj_remap
  import colproj_pkg::*;
#(
  parameter logic [31:0] WIN_BASE  = 32'h4000_0000,
  parameter logic [31:0] WIN_BYTES = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_idx,
  input  logic [31:0] cfg_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data,
  output logic        rsp_last,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  localparam int unsigned LINE_SHIFT = $clog2(LINE_WORDS * WORD_BYTES);

  geom_t             geom;
  logic              idle;
  logic              start;
  logic              advance;
  logic              word_zero;
  logic [ADDR_W-1:0] line_addr;
  logic [ADDR_W-1:0] line_off;
  logic              in_win;

  assign line_addr = (req_addr >> LINE_SHIFT) << LINE_SHIFT;
  assign line_off  = line_addr - WIN_BASE;
  assign in_win    = (line_addr >= WIN_BASE) && (line_off < WIN_BYTES);

  colproj_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_wdata),
    .idle    (idle),
    .geom    (geom)
  );

  colproj_walk u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .advance   (advance),
    .remap_in  (in_win),
    .line_off  (line_off),
    .line_addr (line_addr),
    .geom_in   (geom),
    .word_addr (mem_req_addr),
    .word_zero (word_zero)
  );

  colproj_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_data      (rsp_data),
    .rsp_last      (rsp_last),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .word_zero     (word_zero),
    .start         (start),
    .advance       (advance),
    .idle          (idle)
  );
endmodule

// File: rtl/colproj_remap_chk.sv
module colproj_remap_chk
  import colproj_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        rsp_last,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input geom_t       geom,
  input logic        word_zero
);
  // R6: accepting a request makes the engine busy on the next cycle
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R6: the final word handshake frees the request channel
  a_r6_free_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && rsp_last) |=> req_ready);

  // R6: a stalled returned word holds
  a_r6_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));

  // R7: a stalled memory request keeps its address
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4: a zero-filled word is delivered as zero
  a_r4_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && word_zero) |-> (rsp_data == '0));

  // R8: a write while busy leaves the geometry untouched
  a_r8_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !req_ready) |=> $stable(geom));
endmodule

bind colproj_remap colproj_remap_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .rsp_last      (rsp_last),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .geom          (geom),
  .word_zero     (word_zero)
);

// File: tb/colproj_remap_test.sv
`timescale 1ns/1ps
module colproj_remap_test;
  localparam logic [31:0] WB = 32'h4000_0000;
  localparam logic [31:0] WS = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rsp_last;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  int stall_ctr = 0;
  int tick = 0;
  int hold_err = 0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;

  logic [31:0] m_base, m_pitch, m_rows;
  logic [7:0]  m_mask;
  logic [31:0] got [16];
  int got_reads, last_err, busy_err;

  always #4 clk = ~clk;

  colproj_remap #(.WIN_BASE(WB), .WIN_BYTES(WS)) uut (.*);

  function automatic logic [31:0] pattern(input logic [31:0] a);
    return (a * 32'h0001_0003) + 32'h0000_1357;
  endfunction

  // memory model: random-ish ready, one-cycle response after handshake
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      stall_ctr     <= stall_ctr + 1;
      mem_req_ready <= (stall_ctr % 3) != 1;
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      mem_rsp_data  <= pattern(mem_req_addr);
      if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + 1;
    end
  end

  // R7 monitor: address of a stalled request must not move
  always @(negedge clk) begin
    if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) hold_err <= hold_err + 1;
    prev_stall <= mem_req_valid && !mem_req_ready;
    prev_addr  <= mem_req_addr;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_cfg(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (idx)
      2'd0: m_base = d;
      2'd1: m_pitch = d;
      2'd2: m_rows = d;
      default: m_mask = d[7:0];
    endcase
  endtask

  task automatic set_geom(input logic [31:0] b, input logic [31:0] p,
                          input logic [31:0] r, input logic [7:0] m);
    do_cfg(2'd0, b); do_cfg(2'd1, p); do_cfg(2'd2, r); do_cfg(2'd3, {24'h0, m});
  endtask

  // expected word and whether it needs a read, computed from the requirements
  function automatic logic [31:0] model_word(input logic [31:0] a, input int j, output bit rd);
    logic [31:0] line, k, s, row, pos, seen, col;
    line = a & ~32'h3F;
    if (!(line >= WB && (line - WB) < WS)) begin
      rd = 1'b1;
      return pattern(line + 32'(4 * j));
    end
    k = (line - WB) / 4 + 32'(j);
    s = 0;
    for (int c = 0; c < 8; c++) s = s + 32'(m_mask[c]);
    if (s == 0) begin rd = 1'b0; return '0; end
    row = k / s;
    if (row >= m_rows) begin rd = 1'b0; return '0; end
    pos = k - row * s;
    seen = 0; col = 0;
    for (int c = 0; c < 8; c++) begin
      if (m_mask[c]) begin
        if (seen == pos) col = 32'(c);
        seen = seen + 1;
      end
    end
    rd = 1'b1;
    return pattern(m_base + row * m_pitch + col * 4);
  endfunction

  task automatic run_line(input logic [31:0] a, input bit poke);
    int n, r0;
    bit poked;
    n = 0; poked = 1'b0; last_err = 0; busy_err = 0;
    r0 = rd_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    while (n < 16) begin
      @(negedge clk);
      tick++;
      rsp_ready = (tick % 4) != 2;
      if (poke && n == 5 && !poked) begin
        cfg_we = 1'b1; cfg_idx = 2'd3; cfg_wdata = 32'h1; poked = 1'b1;
      end else begin
        cfg_we = 1'b0;
      end
      if (req_ready) busy_err++;
      if (rsp_valid && rsp_ready) begin
        got[n] = rsp_data;
        if (rsp_last != (n == 15)) last_err++;
        n++;
      end
    end
    cfg_we = 1'b0;
    @(posedge clk);
    #1 got_reads = rd_cnt - r0;
  endtask

  task automatic line_check(input logic [31:0] a, input bit poke, input string tag);
    logic [31:0] e, bad_act, bad_exp, z_act;
    int exp_reads, dmis, zmis;
    bit rd;
    run_line(a, poke);
    exp_reads = 0; dmis = 0; zmis = 0;
    bad_act = 0; bad_exp = 0; z_act = 0;
    for (int j = 0; j < 16; j++) begin
      e = model_word(a, j, rd);
      if (rd) begin
        exp_reads++;
        if (got[j] !== e) begin
          if (dmis == 0) begin bad_act = got[j]; bad_exp = e; end
          dmis++;
        end
      end else if (got[j] !== 32'h0) begin
        if (zmis == 0) z_act = got[j];
        zmis++;
      end
    end
    check(dmis == 0, tag, $sformatf("data line %h", a), bad_act, bad_exp);
    check(zmis == 0, "R4", $sformatf("zero fill line %h", a), z_act, 32'h0);
    check(got_reads == exp_reads, "R5", $sformatf("read count line %h", a),
          32'(got_reads), 32'(exp_reads));
    check(last_err == 0, "R6", "last flag placement", 32'(last_err), 32'h0);
    check(busy_err == 0, "R6", "ready low while busy", 32'(busy_err), 32'h0);
  endtask

  initial begin
    #(8 * 190000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_base = 0; m_pitch = 0; m_rows = 0; m_mask = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(req_ready === 1'b1, "R1", "ready after reset", 32'(req_ready), 32'h1);
    check(rsp_valid === 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
    check(mem_req_valid === 1'b0, "R1", "mem_req_valid after reset", 32'(mem_req_valid), 32'h0);
    // R1: reset mask zero -> all zero, no reads
    line_check(WB, 1'b0, "R1");

    // R2: passthrough lines, including the first address past the window
    line_check(32'h0000_2040, 1'b0, "R2");
    line_check(WB - 32'd64, 1'b0, "R2");
    line_check(WB + WS, 1'b0, "R2");

    // R3: sweep every column mask over several lines
    for (int m = 0; m < 256; m++) begin
      set_geom(32'h0001_0000 + 32'(m) * 32'h100, 32'd32 + 32'(4 * (m % 3)), 32'd5, 8'(m));
      line_check(WB, 1'b0, "R3");
      line_check(WB + 32'd64, 1'b0, "R3");
      line_check(WB + 32'd128, 1'b0, "R3");
      if (m % 16 == 5) line_check(WB + WS - 32'd64, 1'b0, "R4");
    end

    // R2: low address bits ignored
    set_geom(32'h0003_0000, 32'd48, 32'd40, 8'b1010_0110);
    line_check(WB + 32'd64 + 32'd7, 1'b0, "R2");
    line_check(WB + 32'd64 + 32'd63, 1'b0, "R2");
    line_check(WB + 32'd192, 1'b0, "R3");

    // R8: mask write during a refill is dropped for this and later lines
    set_geom(32'h0005_0000, 32'd32, 32'd5, 8'hFF);
    line_check(WB, 1'b1, "R8");
    line_check(WB + 32'd64, 1'b0, "R8");

    @(negedge clk);
    check(hold_err == 0, "R7", "stalled address stable", 32'(hold_err), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule